// File: doc/BRIEF.md
# Snooping MESI Cache Set Controller

This block keeps one set of a set-associative cache for a single processor on a shared snooping bus. Each way holds a two-bit coherence state, an address tag and one data word that stands for the line. The processor side issues loads and stores. The block answers hits locally. For misses and ownership upgrades it raises bus requests. It also watches requests from other caches and supplies dirty data or gives up its copy when they ask for it.

Only one bus transaction is outstanding at a time. While it is in flight, and in any cycle that carries a snoop, the processor port is held off through its ready signal. Refills go to an empty way when one exists. Otherwise a round-robin pointer names the victim. A dirty victim is written back before the refill request is raised.

Top module: `mesi_set_ctrl`

## Requirements
- R1: Reset is active low on `rst_n` and is released through two flops. All ways start invalid. `cpu_ready` rises on the second clock edge after `rst_n` goes high. `cpu_done` and `bus_req_valid` are low.
- R2: A load that hits gives `cpu_done` with the line data on `cpu_rdata` in the cycle after acceptance, and no bus request is made.
- R3: A store that hits a line in exclusive (2) or modified (3) state completes in the cycle after acceptance with no bus request. The line becomes modified and holds the store data.
- R4: A store that hits a shared (1) line raises an upgrade request (`bus_req_cmd` 2) for its tag. It completes in the cycle after `bus_gnt`, and the line becomes modified.
- R5: A load miss raises a read request (`bus_req_cmd` 0) carrying the requested tag. On `bus_gnt` the line is filled from `bus_resp_data`, that value is returned on `cpu_rdata`, and the state is exclusive if `bus_resp_shared` is low and shared if it is high.
- R6: A store miss raises a read-for-ownership request (`bus_req_cmd` 1). On `bus_gnt` the line is filled with the store data in modified state.
- R7: The refill victim is the lowest-numbered invalid way if any exists. Otherwise it is the way named by a round-robin pointer that starts at 0 and advances by one, wrapping, on each such eviction.
- R8: A modified victim is first written back (`bus_req_cmd` 3, with its own tag and data), and the refill request follows only after that grant. Shared or exclusive victims are dropped with no writeback.
- R9: A read snoop (`snp_excl` low) that hits a line raises `snp_hit` in the same cycle and leaves the line shared. If the line was modified, `snp_flush` is high and `snp_data` carries its data.
- R10: An exclusive snoop (`snp_excl` high, for read-for-ownership or invalidate) that hits any valid line invalidates it. A modified line is flushed on `snp_data` in that cycle.
- R11: `cpu_ready` is low whenever a bus request is pending and in any cycle in which `snp_valid` is high. A snoop that coincides with a processor request is applied first.
- R12: A snoop whose tag matches no valid way gives `snp_hit` and `snp_flush` low and changes no line state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_tag | input | TAG_W | Line address tag of the request |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Request accepted when high together with cpu_valid |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Load result, valid with cpu_done |
| bus_req_valid | output | 1 | Bus request pending |
| bus_req_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 upgrade, 3 writeback |
| bus_req_tag | output | TAG_W | Tag of the requested or written-back line |
| bus_req_data | output | DATA_W | Writeback data |
| bus_gnt | input | 1 | Request completed this cycle |
| bus_resp_data | input | DATA_W | Fill data, valid with bus_gnt |
| bus_resp_shared | input | 1 | Another cache keeps a copy of the filled line |
| snp_valid | input | 1 | Snoop from another cache present |
| snp_excl | input | 1 | Snoop wants ownership or invalidation |
| snp_tag | input | TAG_W | Tag of the snooped line |
| snp_hit | output | 1 | Snooped line present here |
| snp_flush | output | 1 | Snooped line was dirty; data supplied |
| snp_data | output | DATA_W | Supplied line data |

## Verification
The assertions assume that snoops arrive only while no bus request of this block is pending, so a snoop never races with a fill, writeback or upgrade of the same way. They also assume that `bus_gnt` is high only while `bus_req_valid` is high. The stimulus issues snoops only between processor operations or together with a fresh request while the controller is idle. Its bus responder grants each pending request after a fixed two-cycle latency. Fills only install tags that have just missed, so no tag is ever present in two ways.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    LS_I = 2'd0,
    LS_S = 2'd1,
    LS_E = 2'd2,
    LS_M = 2'd3
  } line_st_t;

  typedef enum logic [1:0] {
    BQ_READ  = 2'd0,
    BQ_READX = 2'd1,
    BQ_UPGR  = 2'd2,
    BQ_WBACK = 2'd3
  } bus_op_t;

  typedef enum logic [1:0] {
    FS_IDLE,
    FS_WBACK,
    FS_FILL,
    FS_UPGR
  } ctl_st_t;
endpackage

// File: rtl/mesi_rst_sync.sv
module mesi_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/mesi_lookup.sv
module mesi_lookup import mesi_pkg::*; #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  parameter int IDX_W = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [WAYS-1:0][1:0]         line_st,
  input  logic [WAYS-1:0][TAG_W-1:0]   line_tag,
  input  logic [TAG_W-1:0]             key,
  output logic                         hit,
  output logic [IDX_W-1:0]             hit_idx,
  output logic [1:0]                   hit_st
);
  logic [WAYS-1:0] match;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign match[g] = (line_st[g] != LS_I) && (line_tag[g] == key);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (match[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit    = |match;
  assign hit_st = line_st[hit_idx];

  // a tag may live in at most one valid way (R2)
  assert_one_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
endmodule

// File: rtl/mesi_victim.sv
module mesi_victim import mesi_pkg::*; #(
  parameter int WAYS  = 4,
  parameter int IDX_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [WAYS-1:0][1:0] line_st,
  input  logic                 advance,
  output logic [IDX_W-1:0]     victim,
  output logic                 any_free
);
  logic [WAYS-1:0]  free;
  logic [IDX_W-1:0] first_free;
  logic [IDX_W-1:0] rr_q, rr_d;

  for (genvar g = 0; g < WAYS; g++) begin : g_free
    assign free[g] = (line_st[g] == LS_I);
  end

  always_comb begin
    first_free = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (free[i]) first_free = IDX_W'(i);
    end
  end

  assign any_free = |free;
  assign victim   = any_free ? first_free : rr_q;

  always_comb begin
    rr_d = rr_q;
    if (advance) rr_d = (rr_q == IDX_W'(WAYS - 1)) ? '0 : rr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else        rr_q <= rr_d;
  end

  // an empty way is always preferred over the pointer (R7)
  assert_victim_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    any_free |-> (line_st[victim] == LS_I));

  // the pointer moves only on an eviction of a valid way (R7)
  assert_rr_only_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> !any_free);
endmodule

// File: rtl/mesi_set_ctrl.sv
module mesi_set_ctrl import mesi_pkg::*; #(
  parameter int WAYS   = 4,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [TAG_W-1:0]  cpu_tag,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req_valid,
  output logic [1:0]        bus_req_cmd,
  output logic [TAG_W-1:0]  bus_req_tag,
  output logic [DATA_W-1:0] bus_req_data,
  input  logic              bus_gnt,
  input  logic [DATA_W-1:0] bus_resp_data,
  input  logic              bus_resp_shared,
  input  logic              snp_valid,
  input  logic              snp_excl,
  input  logic [TAG_W-1:0]  snp_tag,
  output logic              snp_hit,
  output logic              snp_flush,
  output logic [DATA_W-1:0] snp_data
);
  localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic rst_int;

  logic [WAYS-1:0][1:0]        st_q, st_d;
  logic [WAYS-1:0][TAG_W-1:0]  tag_q, tag_d;
  logic [WAYS-1:0][DATA_W-1:0] dat_q, dat_d;
  logic                        arr_we;

  ctl_st_t           fsm_q, fsm_d;
  logic [IDX_W-1:0]  way_q, way_d;
  logic              rwr_q, rwr_d;
  logic [TAG_W-1:0]  rtag_q, rtag_d;
  logic [DATA_W-1:0] rwd_q, rwd_d;
  logic              done_q, done_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  logic             hit_c, hit_s, any_free, accept, advance;
  logic [IDX_W-1:0] way_c, way_s, vic_idx;
  logic [1:0]       sth_c, sth_s;

  mesi_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_int)
  );

  mesi_lookup #(.WAYS(WAYS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_cpu_lkp (
    .clk      (clk),
    .rst_n    (rst_int),
    .line_st  (st_q),
    .line_tag (tag_q),
    .key      (cpu_tag),
    .hit      (hit_c),
    .hit_idx  (way_c),
    .hit_st   (sth_c)
  );

  mesi_lookup #(.WAYS(WAYS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_snp_lkp (
    .clk      (clk),
    .rst_n    (rst_int),
    .line_st  (st_q),
    .line_tag (tag_q),
    .key      (snp_tag),
    .hit      (hit_s),
    .hit_idx  (way_s),
    .hit_st   (sth_s)
  );

  mesi_victim #(.WAYS(WAYS), .IDX_W(IDX_W)) u_vic (
    .clk      (clk),
    .rst_n    (rst_int),
    .line_st  (st_q),
    .advance  (advance),
    .victim   (vic_idx),
    .any_free (any_free)
  );

  assign cpu_ready = rst_int && (fsm_q == FS_IDLE) && !snp_valid;
  assign accept    = cpu_valid && cpu_ready;
  assign advance   = accept && !hit_c && !any_free;

  // next-state process: processor side first, snoop applied last so it wins
  always_comb begin
    st_d    = st_q;
    tag_d   = tag_q;
    dat_d   = dat_q;
    arr_we  = 1'b0;
    fsm_d   = fsm_q;
    way_d   = way_q;
    rwr_d   = rwr_q;
    rtag_d  = rtag_q;
    rwd_d   = rwd_q;
    done_d  = 1'b0;
    rdata_d = rdata_q;

    case (fsm_q)
      FS_IDLE: begin
        if (accept) begin
          rwr_d  = cpu_write;
          rtag_d = cpu_tag;
          rwd_d  = cpu_wdata;
          if (hit_c) begin
            if (!cpu_write) begin
              rdata_d = dat_q[way_c];
              done_d  = 1'b1;
            end else if (sth_c == LS_S) begin
              way_d = way_c;
              fsm_d = FS_UPGR;
            end else begin
              dat_d[way_c] = cpu_wdata;
              st_d[way_c]  = LS_M;
              arr_we       = 1'b1;
              done_d       = 1'b1;
            end
          end else begin
            way_d = vic_idx;
            fsm_d = (st_q[vic_idx] == LS_M) ? FS_WBACK : FS_FILL;
          end
        end
      end
      FS_WBACK: begin
        if (bus_gnt) begin
          st_d[way_q] = LS_I;
          fsm_d       = FS_FILL;
        end
      end
      FS_FILL: begin
        if (bus_gnt) begin
          tag_d[way_q] = rtag_q;
          arr_we       = 1'b1;
          if (rwr_q) begin
            dat_d[way_q] = rwd_q;
            st_d[way_q]  = LS_M;
          end else begin
            dat_d[way_q] = bus_resp_data;
            st_d[way_q]  = bus_resp_shared ? LS_S : LS_E;
            rdata_d      = bus_resp_data;
          end
          done_d = 1'b1;
          fsm_d  = FS_IDLE;
        end
      end
      FS_UPGR: begin
        if (st_q[way_q] == LS_I) begin
          fsm_d = FS_FILL;
        end else if (bus_gnt) begin
          dat_d[way_q] = rwd_q;
          st_d[way_q]  = LS_M;
          arr_we       = 1'b1;
          done_d       = 1'b1;
          fsm_d        = FS_IDLE;
        end
      end
      default: fsm_d = FS_IDLE;
    endcase

    if (snp_valid && hit_s) begin
      st_d[way_s] = snp_excl ? LS_I : LS_S;
    end
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      st_q    <= '0;
      fsm_q   <= FS_IDLE;
      way_q   <= '0;
      rwr_q   <= 1'b0;
      rtag_q  <= '0;
      rwd_q   <= '0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      st_q    <= st_d;
      fsm_q   <= fsm_d;
      way_q   <= way_d;
      rwr_q   <= rwr_d;
      rtag_q  <= rtag_d;
      rwd_q   <= rwd_d;
      done_q  <= done_d;
      rdata_q <= rdata_d;
    end
  end

  always_ff @(posedge clk) begin
    if (arr_we) begin
      tag_q <= tag_d;
      dat_q <= dat_d;
    end
  end

  always_comb begin
    bus_req_valid = (fsm_q != FS_IDLE);
    bus_req_cmd   = BQ_READ;
    bus_req_tag   = rtag_q;
    case (fsm_q)
      FS_WBACK: begin
        bus_req_cmd = BQ_WBACK;
        bus_req_tag = tag_q[way_q];
      end
      FS_FILL: bus_req_cmd = rwr_q ? BQ_READX : BQ_READ;
      FS_UPGR: bus_req_cmd = BQ_UPGR;
      default: bus_req_cmd = BQ_READ;
    endcase
  end

  assign bus_req_data = dat_q[way_q];
  assign cpu_done     = done_q;
  assign cpu_rdata    = rdata_q;
  assign snp_hit      = snp_valid && hit_s;
  assign snp_flush    = snp_hit && (sth_s == LS_M);
  assign snp_data     = dat_q[way_s];

  assert_load_hit_local_R2: assert property (@(posedge clk) disable iff (!rst_int)
    (accept && !cpu_write && hit_c) |=> (cpu_done && !bus_req_valid));

  assert_owned_store_silent_R3: assert property (@(posedge clk) disable iff (!rst_int)
    (accept && cpu_write && hit_c && (sth_c == LS_E || sth_c == LS_M))
      |=> (cpu_done && !bus_req_valid));

  assert_shared_store_upgrades_R4: assert property (@(posedge clk) disable iff (!rst_int)
    (accept && cpu_write && hit_c && sth_c == LS_S)
      |=> (bus_req_valid && bus_req_cmd == BQ_UPGR && !cpu_done));

  assert_wb_before_fill_R8: assert property (@(posedge clk) disable iff (!rst_int)
    (bus_req_valid && (bus_req_cmd == BQ_READ || bus_req_cmd == BQ_READX))
      |-> (st_q[way_q] != LS_M));

  assert_excl_snoop_kills_R10: assert property (@(posedge clk) disable iff (!rst_int)
    (snp_hit && snp_excl && fsm_q == FS_IDLE) |=> (st_q[$past(way_s)] == LS_I));

  assert_snoop_blocks_cpu_R11: assert property (@(posedge clk) disable iff (!rst_int)
    (snp_valid || bus_req_valid) |-> !cpu_ready);
endmodule

// File: tb/mesi_set_ctrl_test.sv
module mesi_set_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 4;

  logic        clk, rst_n;
  logic        cpu_valid, cpu_write;
  logic [7:0]  cpu_tag;
  logic [31:0] cpu_wdata;
  logic        cpu_ready, cpu_done;
  logic [31:0] cpu_rdata;
  logic        bus_req_valid;
  logic [1:0]  bus_req_cmd;
  logic [7:0]  bus_req_tag;
  logic [31:0] bus_req_data;
  logic        bus_gnt;
  logic [31:0] bus_resp_data;
  logic        bus_resp_shared;
  logic        snp_valid, snp_excl;
  logic [7:0]  snp_tag;
  logic        snp_hit, snp_flush;
  logic [31:0] snp_data;

  mesi_set_ctrl #(.WAYS(NW), .TAG_W(8), .DATA_W(32)) uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_tag(cpu_tag),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_done(cpu_done),
    .cpu_rdata(cpu_rdata),
    .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd),
    .bus_req_tag(bus_req_tag), .bus_req_data(bus_req_data),
    .bus_gnt(bus_gnt), .bus_resp_data(bus_resp_data),
    .bus_resp_shared(bus_resp_shared),
    .snp_valid(snp_valid), .snp_excl(snp_excl), .snp_tag(snp_tag),
    .snp_hit(snp_hit), .snp_flush(snp_flush), .snp_data(snp_data)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit share_flag = 1'b0;

  int          cmd_log[$];
  logic [7:0]  wb_tag;
  logic [31:0] wb_data;
  logic [31:0] last_rdata;
  logic        s_hit, s_flush;
  logic [31:0] s_data;

  // reference model state
  int          m_st[NW];
  logic [7:0]  m_tag[NW];
  logic [31:0] m_dat[NW];
  int          m_rr, m_phase, m_way, m_rs;
  bit          m_done, m_wr, m_rdop;
  logic [7:0]  m_rtag;
  logic [31:0] m_wd, m_rdata;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  function automatic int m_find(logic [7:0] t);
    for (int w = 0; w < NW; w++) if (m_st[w] != 0 && m_tag[w] == t) return w;
    return -1;
  endfunction

  task automatic model_cycle();
    bit exp_ready;
    int sw;
    bit nd;
    exp_ready = (m_rs >= 2) && (m_phase == 0) && !snp_valid;
    sw = snp_valid ? m_find(snp_tag) : -1;

    chk("R11 cpu_ready", 32'(cpu_ready), 32'(exp_ready));
    chk("R2 cpu_done", 32'(cpu_done), 32'(m_done));
    if (m_done && m_rdop) chk("R2 cpu_rdata", cpu_rdata, m_rdata);
    chk("R8 bus_req_valid", 32'(bus_req_valid), 32'(m_phase != 0));
    if (m_phase != 0) begin
      int ec;
      ec = (m_phase == 1) ? 3 : (m_phase == 3) ? 2 : (m_wr ? 1 : 0);
      chk("R5 bus_req_cmd", 32'(bus_req_cmd), 32'(ec));
      chk("R5 bus_req_tag", 32'(bus_req_tag), 32'((m_phase == 1) ? m_tag[m_way] : m_rtag));
      if (m_phase == 1) chk("R8 bus_req_data", bus_req_data, m_dat[m_way]);
    end
    chk("R12 snp_hit", 32'(snp_hit), 32'(sw >= 0));
    chk("R9 snp_flush", 32'(snp_flush), 32'(sw >= 0 && m_st[sw] == 3));
    if (sw >= 0 && m_st[sw] == 3) chk("R10 snp_data", snp_data, m_dat[sw]);

    if (!rst_n) begin
      for (int w = 0; w < NW; w++) m_st[w] = 0;
      m_phase = 0; m_done = 0; m_rs = 0; m_rr = 0;
      return;
    end
    nd = 0;
    case (m_phase)
      0: if (cpu_valid && exp_ready) begin
        int w;
        w = m_find(cpu_tag);
        m_wr = cpu_write; m_rtag = cpu_tag; m_wd = cpu_wdata; m_rdop = !cpu_write;
        if (w >= 0) begin
          if (!cpu_write) begin m_rdata = m_dat[w]; nd = 1; end
          else if (m_st[w] == 1) begin m_phase = 3; m_way = w; end
          else begin m_dat[w] = cpu_wdata; m_st[w] = 3; nd = 1; end
        end else begin
          int v;
          v = -1;
          for (int k = NW - 1; k >= 0; k--) if (m_st[k] == 0) v = k;
          if (v < 0) begin v = m_rr; m_rr = (m_rr + 1) % NW; end
          m_way = v;
          m_phase = (m_st[v] == 3) ? 1 : 2;
        end
      end
      1: if (bus_gnt) begin m_st[m_way] = 0; m_phase = 2; end
      2: if (bus_gnt) begin
        m_tag[m_way] = m_rtag;
        if (m_wr) begin m_dat[m_way] = m_wd; m_st[m_way] = 3; end
        else begin
          m_dat[m_way] = bus_resp_data;
          m_st[m_way] = bus_resp_shared ? 1 : 2;
          m_rdata = bus_resp_data;
        end
        nd = 1; m_phase = 0;
      end
      3: if (m_st[m_way] == 0) m_phase = 2;
         else if (bus_gnt) begin
           m_dat[m_way] = m_wd; m_st[m_way] = 3; nd = 1; m_phase = 0;
         end
      default: m_phase = 0;
    endcase
    if (sw >= 0) m_st[sw] = snp_excl ? 0 : 1;
    if (m_rs < 2) m_rs++;
    m_done = nd;
  endtask

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  // per-cycle comparison, bus log and watchdog
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (bus_req_valid && bus_gnt) begin
        cmd_log.push_back(int'(bus_req_cmd));
        if (bus_req_cmd == 2'd3) begin wb_tag = bus_req_tag; wb_data = bus_req_data; end
      end
      model_cycle();
      if (cyc > 20000) begin
        total++; bad++;
        $display("FAIL R11 watchdog act=%0d exp=%0d", cyc, 20000);
        finish_run();
      end
    end
  end

  // bus responder: grant every request on its second cycle
  initial begin
    int lat;
    lat = 0;
    bus_gnt = 1'b0; bus_resp_data = '0; bus_resp_shared = 1'b0;
    forever begin
      @(posedge clk); #1;
      if (bus_req_valid) begin
        if (lat == 1) begin bus_gnt = 1'b1; lat = 0; end
        else begin bus_gnt = 1'b0; lat++; end
      end else begin
        bus_gnt = 1'b0; lat = 0;
      end
      bus_resp_data   = 32'hD000_0000 | 32'(bus_req_tag);
      bus_resp_shared = share_flag;
    end
  end

  task automatic wait_done();
    do @(negedge clk); while (!cpu_done);
    last_rdata = cpu_rdata;
  endtask

  task automatic cpu_op(bit wr, logic [7:0] tg, logic [31:0] wd);
    cmd_log.delete();
    @(posedge clk); #1;
    cpu_valid = 1'b1; cpu_write = wr; cpu_tag = tg; cpu_wdata = wd;
    do @(negedge clk); while (!cpu_ready);
    @(posedge clk); #1;
    cpu_valid = 1'b0;
    wait_done();
  endtask

  task automatic snoop(bit ex, logic [7:0] tg);
    @(posedge clk); #1;
    snp_valid = 1'b1; snp_excl = ex; snp_tag = tg;
    @(negedge clk);
    s_hit = snp_hit; s_flush = snp_flush; s_data = snp_data;
    @(posedge clk); #1;
    snp_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    cpu_valid = 1'b0; cpu_write = 1'b0; cpu_tag = '0; cpu_wdata = '0;
    snp_valid = 1'b0; snp_excl = 1'b0; snp_tag = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 ready after reset", 32'(cpu_ready), 32'd1);
    chk("R1 no bus request after reset", 32'(bus_req_valid), 32'd0);
    chk("R1 no done after reset", 32'(cpu_done), 32'd0);

    // R5: load miss, no sharer -> exclusive
    share_flag = 1'b0;
    cpu_op(1'b0, 8'h01, '0);
    chk("R5 read miss bus ops", 32'(cmd_log.size()), 32'd1);
    if (cmd_log.size() == 1) chk("R5 read cmd", 32'(cmd_log[0]), 32'd0);
    chk("R5 fill data returned", last_rdata, 32'hD000_0001);

    // R3: store to exclusive line is silent
    cpu_op(1'b1, 8'h01, 32'h1111_0001);
    chk("R3 exclusive store bus ops", 32'(cmd_log.size()), 32'd0);

    // R9: read snoop on modified line flushes and shares
    snoop(1'b0, 8'h01);
    chk("R9 snoop hit", 32'(s_hit), 32'd1);
    chk("R9 snoop flush", 32'(s_flush), 32'd1);
    chk("R9 snoop data", s_data, 32'h1111_0001);

    // R4: store to shared line upgrades
    cpu_op(1'b1, 8'h01, 32'h2222_0001);
    chk("R4 upgrade bus ops", 32'(cmd_log.size()), 32'd1);
    if (cmd_log.size() == 1) chk("R4 upgrade cmd", 32'(cmd_log[0]), 32'd2);

    // R10: exclusive snoop flushes and invalidates
    snoop(1'b1, 8'h01);
    chk("R10 excl snoop flush", 32'(s_flush), 32'd1);
    chk("R10 excl snoop data", s_data, 32'h2222_0001);
    snoop(1'b0, 8'h01);
    chk("R10 line gone after excl snoop", 32'(s_hit), 32'd0);

    // fill the set: 02 S, 03 M, 04 E, 05 E
    share_flag = 1'b1;
    cpu_op(1'b0, 8'h02, '0);
    share_flag = 1'b0;
    cpu_op(1'b1, 8'h03, 32'h3333_0003);
    chk("R6 write miss bus ops", 32'(cmd_log.size()), 32'd1);
    if (cmd_log.size() == 1) chk("R6 rfo cmd", 32'(cmd_log[0]), 32'd1);
    cpu_op(1'b0, 8'h04, '0);
    cpu_op(1'b0, 8'h05, '0);

    // R8: shared victim (way 0) dropped without writeback
    cpu_op(1'b0, 8'h06, '0);
    chk("R8 clean victim bus ops", 32'(cmd_log.size()), 32'd1);

    // R8: modified victim (way 1) written back before refill
    cpu_op(1'b1, 8'h07, 32'h7777_0007);
    chk("R8 dirty victim bus ops", 32'(cmd_log.size()), 32'd2);
    if (cmd_log.size() == 2) begin
      chk("R8 writeback first", 32'(cmd_log[0]), 32'd3);
      chk("R8 refill second", 32'(cmd_log[1]), 32'd1);
    end
    chk("R8 writeback tag", 32'(wb_tag), 32'h03);
    chk("R8 writeback data", wb_data, 32'h3333_0003);

    // R7: round robin continues at way 2
    cpu_op(1'b0, 8'h04, '0);
    chk("R7 line 04 still present", 32'(cmd_log.size()), 32'd0);
    chk("R2 load hit data", last_rdata, 32'hD000_0004);
    cpu_op(1'b0, 8'h08, '0);
    cpu_op(1'b0, 8'h04, '0);
    chk("R7 line 04 evicted by pointer", 32'(cmd_log.size()), 32'd1);

    // R7: invalid way preferred over pointer (pointer now at way 0)
    snoop(1'b1, 8'h08);
    chk("R10 clean line invalidated without flush", 32'(s_flush), 32'd0);
    cpu_op(1'b0, 8'h09, '0);
    cpu_op(1'b0, 8'h06, '0);
    chk("R7 free way used first", 32'(cmd_log.size()), 32'd0);

    // R11: snoop and store in the same cycle, snoop wins
    cmd_log.delete();
    @(posedge clk); #1;
    snp_valid = 1'b1; snp_excl = 1'b0; snp_tag = 8'h04;
    cpu_valid = 1'b1; cpu_write = 1'b1; cpu_tag = 8'h04; cpu_wdata = 32'h4444_0004;
    @(negedge clk);
    chk("R11 ready low under snoop", 32'(cpu_ready), 32'd0);
    chk("R9 exclusive line snoop hit", 32'(snp_hit), 32'd1);
    @(posedge clk); #1;
    snp_valid = 1'b0;
    do @(negedge clk); while (!cpu_ready);
    @(posedge clk); #1;
    cpu_valid = 1'b0;
    wait_done();
    chk("R11 store after snoop needs upgrade", 32'(cmd_log.size()), 32'd1);

    // R12: snoop miss leaves state alone
    snoop(1'b0, 8'h55);
    chk("R12 snoop miss", 32'(s_hit), 32'd0);
    snoop(1'b0, 8'h04);
    chk("R12 line 04 still modified", 32'(s_flush), 32'd1);
    chk("R12 line 04 data", s_data, 32'h4444_0004);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule